// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between a host processor bus and the register file of a multi-channel serial controller. It samples an active-low chip select, a write/read select, an address and write data on the system clock. For each host access it produces one register strobe toward the rest of the device and a data-acknowledge back to the host. It also holds the bus-mode and reserved-lock bits of the global configuration register, which sits at a parameterised address in the control half of the register space.

Out of reset the interface runs open-ended cycles. A cycle starts when chip select is first sampled low, and it ends when chip select is sampled high again. Software can move the bus to fixed cycles of `SYNC_CLKS` clocks (four by default) with one write that sets the bus-mode bit. The new protocol takes over when chip select negates at the end of that write. A guard window of `GAP_CLKS` clocks (two by default) then follows, in which chip select is ignored and a violation is flagged. Once in fixed-cycle mode, only a hardware or software reset brings the bus back. The top address bit tells the register file which half the access targets.

Top module: `hbus_if`

## Requirements
- R1: After `rst_n` is low, the block is in open-ended mode: `ack`=0, `sync_mode`=0, `bus_viol`=0, `reg_wr`=`reg_rd`=0 and `cfg_q`=0x00.
- R2: In open-ended mode, `ack` goes high in the clock after chip select is first sampled low. It stays high for as long as chip select is sampled low, and it falls in the clock after chip select is sampled high. A cycle of any length produces exactly one strobe.
- R3: An accepted access to an address other than the configuration address gives a one-clock `reg_wr` (when `wr`=1) or `reg_rd` (when `wr`=0) in the first clock of the cycle. In that same clock `reg_addr` and `reg_wdata` hold the sampled values, and `reg_ctl` equals the top address bit (1 = control half). Accesses to the configuration address produce no strobe.
- R4: A write of configuration bit 6 = 1 in open-ended mode does not change `sync_mode` while chip select stays low. During that time `cfg_q` bit 6 reads back as 1. `sync_mode` becomes 1 in the clock after chip select is sampled high at the end of that write.
- R5: For `GAP_CLKS` clocks after the switching write ends, chip select is ignored: no strobe and no `ack`. Every clock in which chip select is sampled low in that window is followed by a one-clock `bus_viol` pulse.
- R6: In fixed-cycle mode, a cycle lasts `SYNC_CLKS` clocks counted from the edge at which chip select is sampled low. The strobe is in clock 1, and `ack` is high only in clock `SYNC_CLKS`.
- R7: In fixed-cycle mode, chip select may stay low across cycles. The edge that ends one cycle starts the next one and takes a new address and data.
- R8: Fixed-cycle mode is left only by `rst_n` or `sw_rst`. A configuration write with bit 6 = 0 leaves `sync_mode` and `cfg_q` bit 6 at 1.
- R9: While configuration bit 7 is 1, accesses to any other address get `ack` but no strobe. The configuration address stays writable, and clearing bit 7 restores strobes.
- R10: Configuration bits 5:3 always read 0 and ignore writes. Bits 2:0 store the written value and read back unchanged.
- R11: A one-clock `sw_rst` pulse returns the block to the state of R1, including open-ended mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Register address; top bit selects control half |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | Data acknowledge to the host |
| bus_viol | output | 1 | Chip select seen inside the post-switch guard window |
| sync_mode | output | 1 | 1 = fixed-cycle bus protocol active |
| cfg_q | output | 8 | Configuration register readback |
| reg_wr | output | 1 | One-clock register write strobe |
| reg_rd | output | 1 | One-clock register read strobe |
| reg_addr | output | ADDR_W | Address latched at cycle start |
| reg_wdata | output | DATA_W | Write data latched at cycle start |
| reg_ctl | output | 1 | Latched top address bit (control half) |

## Verification
The hardest situation to reach is the guard window right after the mode switch. It lasts only two clocks, and it exists only once per reset, after an open-ended write that sets bit 6 has closed. The stimulus runs that switching write and drops chip select in the very next clock, so it lands inside the window. It then raises chip select for one clock and starts the first fixed cycle exactly when the window closes. This shows that the window both flags the violation and releases on time. Leaving fixed-cycle mode needs its own reset each time, so the bench repeats the switch once before the software reset and once before the hardware reset.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic [2:0] {
      ST_A_IDLE,
      ST_A_ACT,
      ST_GAP,
      ST_S_IDLE,
      ST_S_RUN
   } bus_st_e;

   localparam int CFG_W       = 8;
   localparam int CFG_LOCK_B  = 7;
   localparam int CFG_MODE_B  = 6;
   localparam int CFG_LOW_W   = 3;

endpackage

// File: rtl/hbus_seq.sv
module hbus_seq
   import hbus_pkg::*;
#(
   parameter int SYNC_CLKS = 4,
   parameter int GAP_CLKS  = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic cs_n,
   input  logic switch_pend,
   output logic start,
   output logic async_end,
   output logic ack,
   output logic viol,
   output logic sync_mode
);

   localparam int PH_W = $clog2(SYNC_CLKS + 1);
   localparam int GW   = $clog2(GAP_CLKS + 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYNC_CLKS);
   localparam logic [PH_W-1:0] PH_PRE  = PH_W'(SYNC_CLKS - 1);
   localparam logic [GW-1:0]   G_LAST  = GW'(GAP_CLKS - 1);

   generate
      if (SYNC_CLKS < 2) begin : g_bad_sync
         $error("hbus_seq: SYNC_CLKS must be at least 2");
      end
      if (GAP_CLKS < 1) begin : g_bad_gap
         $error("hbus_seq: GAP_CLKS must be at least 1");
      end
   endgenerate

   bus_st_e          st;
   logic [PH_W-1:0]  ph;
   logic [GW-1:0]    gcnt;

   always_comb begin
      case (st)
         ST_A_IDLE: start = !cs_n;
         ST_S_IDLE: start = !cs_n;
         ST_S_RUN:  start = (ph == PH_LAST) && !cs_n;
         default:   start = 1'b0;
      endcase
   end

   assign async_end = (st == ST_A_ACT) && cs_n;
   assign sync_mode = (st == ST_GAP) || (st == ST_S_IDLE) || (st == ST_S_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_A_IDLE;
         ph   <= '0;
         gcnt <= '0;
         ack  <= 1'b0;
         viol <= 1'b0;
      end else if (sw_rst) begin
         st   <= ST_A_IDLE;
         ph   <= '0;
         gcnt <= '0;
         ack  <= 1'b0;
         viol <= 1'b0;
      end else begin
         viol <= 1'b0;
         case (st)
            ST_A_IDLE: begin
               if (!cs_n) begin
                  st  <= ST_A_ACT;
                  ack <= 1'b1;
               end
            end
            ST_A_ACT: begin
               if (cs_n) begin
                  ack <= 1'b0;
                  if (switch_pend) begin
                     st   <= ST_GAP;
                     gcnt <= '0;
                  end else begin
                     st <= ST_A_IDLE;
                  end
               end
            end
            ST_GAP: begin
               viol <= !cs_n;
               if (gcnt == G_LAST) st <= ST_S_IDLE;
               else                gcnt <= gcnt + 1'b1;
            end
            ST_S_IDLE: begin
               if (!cs_n) begin
                  st <= ST_S_RUN;
                  ph <= PH_W'(1);
               end
            end
            ST_S_RUN: begin
               if (ph == PH_PRE) ack <= 1'b1;
               if (ph == PH_LAST) begin
                  ack <= 1'b0;
                  if (!cs_n) ph <= PH_W'(1);
                  else       st <= ST_S_IDLE;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            default: st <= ST_A_IDLE;
         endcase
      end
   end

   // R2: acknowledge held while an open-ended cycle keeps chip select low
   p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (st == ST_A_ACT && !cs_n) |=> ack);

   // R5: chip select inside the guard window is flagged
   p_gap_viol_r5: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (st == ST_GAP && !cs_n) |=> (viol && !ack));

   // R6: fixed-cycle acknowledge is a single-clock pulse
   p_sync_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (sync_mode && ack) |=> !ack);

endmodule

// File: rtl/hbus_cfg.sv
module hbus_cfg
   import hbus_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sync_mode,
   input  logic              async_end,
   output logic              lock,
   output logic              switch_pend,
   output logic [CFG_W-1:0]  cfg_q
);

   logic [CFG_LOW_W-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock        <= 1'b0;
         switch_pend <= 1'b0;
         low_q       <= '0;
      end else if (sw_rst) begin
         lock        <= 1'b0;
         switch_pend <= 1'b0;
         low_q       <= '0;
      end else begin
         if (wr_hit) begin
            lock  <= wdata[CFG_LOCK_B];
            low_q <= wdata[CFG_LOW_W-1:0];
            if (!sync_mode) switch_pend <= wdata[CFG_MODE_B];
         end else if (async_end) begin
            switch_pend <= 1'b0;
         end
      end
   end

   assign cfg_q = {lock, sync_mode | switch_pend,
                   {(CFG_MODE_B - CFG_LOW_W){1'b0}}, low_q};

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode #(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h80
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              start,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lock,
   output logic              cfg_wr_hit,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_ctl
);

   localparam int SPLIT_B = ADDR_W - 1;

   logic is_cfg;
   assign is_cfg     = (addr == CFG_ADDR);
   assign cfg_wr_hit = start && is_cfg && wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
      end else if (sw_rst) begin
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         if (start) begin
            reg_addr  <= addr;
            reg_wdata <= wdata;
            if (!is_cfg && !lock) begin
               reg_wr <= wr;
               reg_rd <= !wr;
            end
         end
      end
   end

   assign reg_ctl = reg_addr[SPLIT_B];

   // R3: a strobe never lasts more than one clock
   p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (reg_wr || reg_rd) |=> (!reg_wr && !reg_rd));

   // R9: with the lock bit set, other addresses get no strobe
   p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      (start && lock && !is_cfg) |=> (!reg_wr && !reg_rd));

endmodule

// File: rtl/hbus_if.sv
module hbus_if
   import hbus_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h80,
   parameter int                SYNC_CLKS = 4,
   parameter int                GAP_CLKS  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              cs_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic              bus_viol,
   output logic              sync_mode,
   output logic [7:0]        cfg_q,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_ctl
);

   generate
      if (DATA_W < CFG_W) begin : g_bad_dw
         $error("hbus_if: DATA_W must cover the configuration register");
      end
      if (CFG_ADDR[ADDR_W-1] != 1'b1) begin : g_bad_cfg
         $error("hbus_if: CFG_ADDR must lie in the control half");
      end
   endgenerate

   logic start, async_end, lock, switch_pend, cfg_wr_hit;

   hbus_seq #(.SYNC_CLKS(SYNC_CLKS), .GAP_CLKS(GAP_CLKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cs_n(cs_n),
      .switch_pend(switch_pend), .start(start), .async_end(async_end),
      .ack(ack), .viol(bus_viol), .sync_mode(sync_mode)
   );

   hbus_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_hit(cfg_wr_hit),
      .wdata(wdata), .sync_mode(sync_mode), .async_end(async_end),
      .lock(lock), .switch_pend(switch_pend), .cfg_q(cfg_q)
   );

   hbus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start(start), .wr(wr),
      .addr(addr), .wdata(wdata), .lock(lock), .cfg_wr_hit(cfg_wr_hit),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_ctl(reg_ctl)
   );

   // R4: fixed-cycle mode begins only after chip select was seen high
   p_mode_switch_r4: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
      $rose(sync_mode) |-> $past(cs_n));

   // R8: only a reset leaves fixed-cycle mode
   p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !sw_rst) |=> sync_mode);

endmodule

// File: tb/hbus_if_tb_top.sv
module hbus_if_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic       cs_n = 1'b1;
   logic       wr = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       ack, bus_viol, sync_mode, reg_wr, reg_rd, reg_ctl;
   logic [7:0] cfg_q, reg_addr, reg_wdata;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   localparam logic [7:0] CFG = 8'h80;

   always #10 clk = ~clk;

   hbus_if dut_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cs_n(cs_n), .wr(wr),
      .addr(addr), .wdata(wdata), .ack(ack), .bus_viol(bus_viol),
      .sync_mode(sync_mode), .cfg_q(cfg_q), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ctl(reg_ctl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Open-ended access; starts at a negedge, ends at the negedge after close.
   task automatic async_acc(input string req, input logic [7:0] a, input logic [7:0] d,
                            input logic w, input int hold, input logic exp_stb);
      cs_n = 1'b0; addr = a; wdata = d; wr = w;
      @(negedge clk);
      chk({req, " ack rise"}, 32'(ack), 32'd1);
      chk({req, " wr stb"}, 32'(reg_wr), 32'(exp_stb && w));
      chk({req, " rd stb"}, 32'(reg_rd), 32'(exp_stb && !w));
      if (exp_stb) begin
         chk({req, " addr"}, 32'(reg_addr), 32'(a));
         chk({req, " ctl"}, 32'(reg_ctl), 32'(a[7]));
         if (w) chk({req, " wdata"}, 32'(reg_wdata), 32'(d));
      end
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk({req, " ack held"}, 32'(ack), 32'd1);
         chk({req, " single stb"}, 32'(reg_wr | reg_rd), 32'd0);
      end
      cs_n = 1'b1;
      @(negedge clk);
      chk({req, " ack fall"}, 32'(ack), 32'd0);
   endtask

   // Fixed cycle; starts at a negedge, leaves cs_n low after clock 4.
   task automatic sync_cyc(input string req, input logic [7:0] a, input logic [7:0] d,
                           input logic w, input logic exp_stb);
      cs_n = 1'b0; addr = a; wdata = d; wr = w;
      @(negedge clk);
      chk({req, " clk1 wr"}, 32'(reg_wr), 32'(exp_stb && w));
      chk({req, " clk1 rd"}, 32'(reg_rd), 32'(exp_stb && !w));
      chk({req, " clk1 ack"}, 32'(ack), 32'd0);
      if (exp_stb) chk({req, " clk1 addr"}, 32'(reg_addr), 32'(a));
      for (int k = 2; k <= 3; k++) begin
         @(negedge clk);
         chk({req, " mid ack"}, 32'(ack), 32'd0);
         chk({req, " mid stb"}, 32'(reg_wr | reg_rd), 32'd0);
      end
      @(negedge clk);
      chk({req, " clk4 ack"}, 32'(ack), 32'd1);
   endtask

   // Switching write plus a clean guard window.
   task automatic do_switch(input bit poke_gap);
      cs_n = 1'b0; addr = CFG; wdata = 8'h40; wr = 1'b1;
      @(negedge clk);
      chk("R4 mode before close", 32'(sync_mode), 32'd0);
      chk("R4 pending readback", 32'(cfg_q), 32'h40);
      @(negedge clk);
      chk("R4 mode still async", 32'(sync_mode), 32'd0);
      cs_n = 1'b1;
      @(negedge clk);
      chk("R4 mode after close", 32'(sync_mode), 32'd1);
      if (poke_gap) begin
         cs_n = 1'b0; addr = 8'h21; wr = 1'b1;
         @(negedge clk);
         chk("R5 viol pulse", 32'(bus_viol), 32'd1);
         chk("R5 no ack in gap", 32'(ack), 32'd0);
         chk("R5 no stb in gap", 32'(reg_wr | reg_rd), 32'd0);
         cs_n = 1'b1;
         @(negedge clk);
         chk("R5 viol clears", 32'(bus_viol), 32'd0);
      end else begin
         repeat (2) @(negedge clk);
         chk("R5 quiet gap", 32'(bus_viol), 32'd0);
      end
   endtask

   task automatic t_reset;
      chk("R1 ack", 32'(ack), 32'd0);
      chk("R1 mode", 32'(sync_mode), 32'd0);
      chk("R1 cfg", 32'(cfg_q), 32'd0);
      chk("R1 viol", 32'(bus_viol), 32'd0);
      chk("R1 stb", 32'(reg_wr | reg_rd), 32'd0);
   endtask

   task automatic t_async;
      async_acc("R2 R3 long write", 8'h12, 8'h5A, 1'b1, 3, 1'b1);
      async_acc("R2 R3 short read", 8'h85, 8'h00, 1'b0, 0, 1'b1);
      async_acc("R2 write b", 8'h7F, 8'hC3, 1'b1, 1, 1'b1);
   endtask

   task automatic t_fields;
      async_acc("R10 cfg write", CFG, 8'h3D, 1'b1, 0, 1'b0);
      chk("R10 reserved zero low kept", 32'(cfg_q), 32'h05);
      async_acc("R10 cfg write b", CFG, 8'h02, 1'b1, 0, 1'b0);
      chk("R10 low bits", 32'(cfg_q), 32'h02);
   endtask

   task automatic t_lock;
      async_acc("R9 set lock", CFG, 8'h80, 1'b1, 0, 1'b0);
      chk("R9 lock readback", 32'(cfg_q), 32'h80);
      async_acc("R9 blocked write", 8'h12, 8'h11, 1'b1, 1, 1'b0);
      async_acc("R9 blocked read", 8'h90, 8'h00, 1'b0, 0, 1'b0);
      async_acc("R9 clear lock", CFG, 8'h00, 1'b1, 0, 1'b0);
      chk("R9 lock cleared", 32'(cfg_q), 32'h00);
      async_acc("R9 restored", 8'h12, 8'h22, 1'b1, 0, 1'b1);
   endtask

   task automatic t_sync;
      do_switch(1'b1);
      sync_cyc("R6 first write", 8'h12, 8'hA5, 1'b1, 1'b1);
      sync_cyc("R7 b2b read", 8'h93, 8'h00, 1'b0, 1'b1);
      sync_cyc("R8 clear attempt", CFG, 8'h00, 1'b1, 1'b0);
      cs_n = 1'b1;
      @(negedge clk);
      chk("R6 ack ends", 32'(ack), 32'd0);
      chk("R8 mode kept", 32'(sync_mode), 32'd1);
      chk("R8 bit6 kept", 32'(cfg_q), 32'h40);
      @(negedge clk);
      sync_cyc("R6 from idle", 8'h44, 8'h3C, 1'b1, 1'b1);
      cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_swrst;
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      chk("R11 mode", 32'(sync_mode), 32'd0);
      chk("R11 cfg", 32'(cfg_q), 32'd0);
      chk("R11 ack", 32'(ack), 32'd0);
      async_acc("R11 async again", 8'h33, 8'h99, 1'b1, 2, 1'b1);
   endtask

   task automatic t_hwrst;
      do_switch(1'b0);
      sync_cyc("R6 before hw reset", 8'h05, 8'h01, 1'b1, 1'b1);
      cs_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R8 hw reset mode", 32'(sync_mode), 32'd0);
      t_reset();
      async_acc("R8 R2 async after reset", 8'h06, 8'h02, 1'b1, 1, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_async();
      t_fields();
      t_lock();
      t_sync();
      t_swrst();
      t_hwrst();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
         $finish;
      end
   end

endmodule